// File: doc/BRIEF.md
# Single-Cycle RISC Core

This block is a compact processor that fetches, decodes and retires one 32-bit instruction in every clock cycle. The program counter, a sixteen-entry register file and a word-addressed data memory are its only state. Everything else is combinational: instruction fetch, decode, operand selection, the ALU, the branch and jump adders and the writeback selection.

The core holds a private instruction store. Its write port is used while the core is held in reset: the loader writes one instruction per cycle. When reset is released, execution starts at address 0. The register write, the data memory write and the program counter are driven to ports. This lets an observer follow every retired instruction.

Encoding. Each instruction is split into these fields:
- `op[31:28]` is the primary opcode.
- `fn[27:24]` is the secondary opcode.
- `rd[23:20]`, `rs[19:16]` and `rlo[15:12]` are register fields.
- `imm[15:0]` is the immediate.

For store and branch, the second source register is taken from the `rd` slot. For register-register ALU operations it is taken from `rlo`.

The ALU function code is `{1'b0, fn}`:

| Code | Operation |
|---|---|
| 0 | add |
| 1 | subtract |
| 4 | and |
| 5 | or |
| 6 | xor |
| 7 | nor |
| 8 | equal |
| 9 | signed less-than |
| A | signed less-or-equal |
| B | not-equal |

Comparisons return 0 or 1 in bit 0. Any other code returns 0.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0 and neither `rf_we_o` nor `dmem_we_o` is asserted. After reset is released, the first instruction fetched is the one at word 0.
- R2: Every instruction other than a taken branch or a jump leaves the next PC equal to PC+4.
- R3: Opcode 0x0 (register ALU) writes `ALU(fn, R[rs], R[rlo])` to `rd`. A value written by one instruction is seen as an operand by the next.
- R4: Opcode 0x8 (immediate ALU) writes `ALU(fn, R[rs], sext(imm))` to `rd`.
- R5: The ALU follows the function code table above. Comparisons are signed and yield 0 or 1, and undefined codes yield 0.
- R6: Opcode 0x9 (load word) writes into `rd` the data memory word at `R[rs]+sext(imm)`. The word index is address bits [9:2].
- R7: Opcode 0x5 (store word) writes `R[rd]` to the data memory at `R[rs]+sext(imm)` and writes no register.
- R8: Opcode 0x2 (branch) computes `ALU(fn, R[rs], R[rd])`. The branch is taken when bit 0 of that result is 1, with target PC+4+4*sext(imm). A branch writes no register.
- R9: Opcode 0xB (jump and link) writes PC+4 to `rd` and loads the PC with `R[rs]+4*sext(imm)`.
- R10: Any other primary opcode writes neither a register nor memory, and advances the PC by 4.
- R11: Words written through the instruction load port during reset are the instructions executed after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Instruction store write enable |
| imem_waddr_i | input | IMEM_AW | Instruction store word index |
| imem_wdata_i | input | 32 | Instruction word to store |
| pc_o | output | DW | Address of the instruction now executing |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | log2(NREG) | Destination register |
| rf_wdata_o | output | DW | Writeback value |
| dmem_we_o | output | 1 | Data memory write this cycle |
| dmem_addr_o | output | DW | Data memory byte address (ALU result) |
| dmem_wdata_o | output | DW | Data memory write value |

## Verification
A corrupted register or memory word stays hidden until an instruction reads it. It then appears on the writeback or store ports in the same cycle as that instruction. A wrong branch decision or target shows on `pc_o` one cycle later. From that point every fetched instruction diverges, so the comparison against an instruction-level model, done every cycle, catches the first wrong cycle. Mixing random programs with loads that follow stores, and with branches and jumps that depend on registers, makes sure stale state is read back soon after it is written.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int IW = 32;

  typedef enum logic [3:0] {
    OP_ALUR  = 4'h0,
    OP_BCOND = 4'h2,
    OP_SW    = 4'h5,
    OP_ALUI  = 4'h8,
    OP_LW    = 4'h9,
    OP_JAL   = 4'hB
  } op_e;

  localparam logic [4:0] FN_ADD = 5'h00;
  localparam logic [4:0] FN_SUB = 5'h01;
  localparam logic [4:0] FN_AND = 5'h04;
  localparam logic [4:0] FN_OR  = 5'h05;
  localparam logic [4:0] FN_XOR = 5'h06;
  localparam logic [4:0] FN_NOR = 5'h07;
  localparam logic [4:0] FN_EQ  = 5'h08;
  localparam logic [4:0] FN_LT  = 5'h09;
  localparam logic [4:0] FN_LE  = 5'h0A;
  localparam logic [4:0] FN_NE  = 5'h0B;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2
  } wb_sel_e;

  typedef struct packed {
    logic       b_imm;
    logic [4:0] alu_fn;
    logic       is_br;
    logic       is_jal;
    logic       mem_we;
    wb_sel_e    wb_sel;
    logic       rf_we;
    logic       rt_hi;
  } ctrl_t;
endpackage

// File: rtl/sc_wmem.sv
module sc_wmem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RAW-1:0] ra_i,
  output logic [DW-1:0]  rda_o,
  input  logic [RAW-1:0] rb_i,
  output logic [DW-1:0]  rdb_o,
  input  logic           we_i,
  input  logic [RAW-1:0] wa_i,
  input  logic [DW-1:0]  wd_i
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rda_o = regs_q[ra_i];
  assign rdb_o = regs_q[rb_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu import sc_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [4:0]    fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    case (fn_i)
      FN_ADD:  y_o = a_i + b_i;
      FN_SUB:  y_o = a_i - b_i;
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_XOR:  y_o = a_i ^ b_i;
      FN_NOR:  y_o = ~(a_i | b_i);
      FN_EQ:   y_o = (a_i == b_i) ? ONE : '0;
      FN_LT:   y_o = ($signed(a_i) <  $signed(b_i)) ? ONE : '0;
      FN_LE:   y_o = ($signed(a_i) <= $signed(b_i)) ? ONE : '0;
      FN_NE:   y_o = (a_i != b_i) ? ONE : '0;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_decode.sv
module sc_decode import sc_pkg::*; (
  input  logic [3:0] op_i,
  input  logic [3:0] fn_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.wb_sel = WB_ALU;
    case (op_i)
      OP_ALUR: begin
        ctrl_o.alu_fn = {1'b0, fn_i};
        ctrl_o.rf_we  = 1'b1;
      end
      OP_ALUI: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.alu_fn = {1'b0, fn_i};
        ctrl_o.rf_we  = 1'b1;
      end
      OP_LW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.alu_fn = FN_ADD;
        ctrl_o.wb_sel = WB_MEM;
        ctrl_o.rf_we  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.alu_fn = FN_ADD;
        ctrl_o.mem_we = 1'b1;
        ctrl_o.rt_hi  = 1'b1;
      end
      OP_BCOND: begin
        ctrl_o.alu_fn = {1'b0, fn_i};
        ctrl_o.is_br  = 1'b1;
        ctrl_o.rt_hi  = 1'b1;
      end
      OP_JAL: begin
        ctrl_o.is_jal = 1'b1;
        ctrl_o.wb_sel = WB_LINK;
        ctrl_o.rf_we  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core import sc_pkg::*; #(
  parameter int DW      = 32,
  parameter int NREG    = 16,
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    imem_we_i,
  input  logic [IMEM_AW-1:0]      imem_waddr_i,
  input  logic [IW-1:0]           imem_wdata_i,
  output logic [DW-1:0]           pc_o,
  output logic                    rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [DW-1:0]           rf_wdata_o,
  output logic                    dmem_we_o,
  output logic [DW-1:0]           dmem_addr_o,
  output logic [DW-1:0]           dmem_wdata_o
);
  localparam int RAW = $clog2(NREG);

  logic [DW-1:0] pc_q, pc_d, pc_plus4, br_tgt, jal_tgt;
  logic [IW-1:0] instr;
  ctrl_t         ctrl;
  logic [RAW-1:0] rs_a, rt_a, rd_a;
  logic [DW-1:0] rs_val, rt_val, imm_sx, off4, alu_b, alu_y, mem_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  sc_wmem #(.AW(IMEM_AW), .DW(IW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (pc_q[IMEM_AW+1:2]),
    .rdata_o (instr)
  );

  sc_decode u_dec (
    .op_i   (instr[31:28]),
    .fn_i   (instr[27:24]),
    .ctrl_o (ctrl)
  );

  assign rd_a = instr[20 +: RAW];
  assign rs_a = instr[16 +: RAW];
  // store and branch take the second source from the rd slot
  assign rt_a = ctrl.rt_hi ? instr[20 +: RAW] : instr[12 +: RAW];

  sc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (rs_a),
    .rda_o  (rs_val),
    .rb_i   (rt_a),
    .rdb_o  (rt_val),
    .we_i   (rf_we_o),
    .wa_i   (rd_a),
    .wd_i   (rf_wdata_o)
  );

  assign imm_sx = {{(DW-16){instr[15]}}, instr[15:0]};
  assign off4   = {imm_sx[DW-3:0], 2'b00};
  assign alu_b  = ctrl.b_imm ? imm_sx : rt_val;

  sc_alu #(.DW(DW)) u_alu (
    .fn_i (ctrl.alu_fn),
    .a_i  (rs_val),
    .b_i  (alu_b),
    .y_o  (alu_y)
  );

  sc_wmem #(.AW(DMEM_AW), .DW(DW)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dmem_we_o),
    .waddr_i (alu_y[DMEM_AW+1:2]),
    .wdata_i (rt_val),
    .raddr_i (alu_y[DMEM_AW+1:2]),
    .rdata_o (mem_rd)
  );

  // dedicated adders keep the ALU free for the branch compare
  assign pc_plus4 = pc_q + DW'(4);
  assign br_tgt   = pc_plus4 + off4;
  assign jal_tgt  = rs_val + off4;

  always_comb begin
    if (ctrl.is_jal)                 pc_d = jal_tgt;
    else if (ctrl.is_br && alu_y[0]) pc_d = br_tgt;
    else                             pc_d = pc_plus4;
  end

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  rf_wdata_o = mem_rd;
      WB_LINK: rf_wdata_o = pc_plus4;
      default: rf_wdata_o = alu_y;
    endcase
  end

  assign pc_o         = pc_q;
  assign rf_we_o      = ctrl.rf_we & rst_ni;
  assign rf_waddr_o   = rd_a;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk import sc_pkg::*; #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] pc_i,
  input logic [3:0]    op_i,
  input logic [15:0]   imm_i,
  input logic [DW-1:0] rs_val_i,
  input logic          cond_i,
  input logic          rf_we_i,
  input logic [DW-1:0] rf_wdata_i,
  input logic          dmem_we_i
);
  logic [DW-1:0] off4;
  logic          known, taken;

  assign off4  = {{(DW-18){imm_i[15]}}, imm_i, 2'b00};
  assign known = op_i inside {OP_ALUR, OP_ALUI, OP_LW, OP_SW, OP_BCOND, OP_JAL};
  assign taken = (op_i == OP_BCOND) && cond_i;

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_i == '0 && !rf_we_i && !dmem_we_i));

  a_r2_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_JAL && !taken) |=> pc_i == $past(pc_i) + DW'(4));

  a_r7_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SW) |-> (dmem_we_i && !rf_we_i));

  a_r8_branch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |=> pc_i == $past(pc_i) + DW'(4) + $past(off4));

  a_r8_branch_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BCOND) |-> (!rf_we_i && !dmem_we_i));

  a_r9_link_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_JAL) |-> (rf_we_i && rf_wdata_i == pc_i + DW'(4)));

  a_r9_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_JAL) |=> pc_i == $past(rs_val_i + off4));

  a_r10_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> (!rf_we_i && !dmem_we_i));
endmodule

bind sc_core sc_core_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_i       (pc_o),
  .op_i       (instr[31:28]),
  .imm_i      (instr[15:0]),
  .rs_val_i   (rs_val),
  .cond_i     (alu_y[0]),
  .rf_we_i    (rf_we_o),
  .rf_wdata_i (rf_wdata_o),
  .dmem_we_i  (dmem_we_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [7:0]  imem_waddr_i = '0;
  logic [31:0] imem_wdata_i = '0;
  logic [31:0] pc_o, rf_wdata_o, dmem_addr_o, dmem_wdata_o;
  logic        rf_we_o, dmem_we_o;
  logic [3:0]  rf_waddr_o;

  sc_core u_dut (
    .clk_i, .rst_ni, .imem_we_i, .imem_waddr_i, .imem_wdata_i,
    .pc_o, .rf_we_o, .rf_waddr_o, .rf_wdata_o,
    .dmem_we_o, .dmem_addr_o, .dmem_wdata_o
  );

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  logic [31:0] prog [256];
  logic [31:0] m_rf [16];
  logic [31:0] m_dm [256];
  logic        m_dv [256];
  logic [31:0] m_pc;
  string       pc_tag;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h pc=%h t=%0t", req, act, exp, m_pc, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] ref_alu(logic [3:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h4: return a & b;
      4'h5: return a | b;
      4'h6: return a ^ b;
      4'h7: return ~(a | b);
      4'h8: return {31'b0, a == b};
      4'h9: return {31'b0, $signed(a) < $signed(b)};
      4'hA: return {31'b0, $signed(a) <= $signed(b)};
      4'hB: return {31'b0, a != b};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] enc(logic [3:0] op, logic [3:0] fn, logic [3:0] rd,
                                      logic [3:0] rs, logic [15:0] imm);
    return {op, fn, rd, rs, imm};
  endfunction

  // hold reset, load prog[] through the port, reset the model
  task automatic load_and_start();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", pc_o, 32'h0);
    chk("R1", {31'b0, rf_we_o | dmem_we_o}, 32'h0);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      imem_we_i = 1'b1; imem_waddr_i = 8'(i); imem_wdata_i = prog[i];
    end
    @(negedge clk_i);
    imem_we_i = 1'b0;
    chk("R1", pc_o, 32'h0);
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_pc = '0;
    pc_tag = "R1";
    rst_ni = 1'b1;
    #1;
  endtask

  // one instruction: compare outputs against the model, then wait for the edge
  task automatic step();
    logic [31:0] ins, a, sx, p4, y, npc, addr, wd, dd;
    logic [3:0]  op, fn, rd, rs, rlo;
    logic        we, dwe, skip_wd;
    string       tag;
    ins = prog[m_pc[9:2]];
    op = ins[31:28]; fn = ins[27:24]; rd = ins[23:20]; rs = ins[19:16]; rlo = ins[15:12];
    a = m_rf[rs]; sx = sext(ins[15:0]); p4 = m_pc + 4;
    npc = p4; we = 0; dwe = 0; wd = '0; dd = '0; addr = '0; skip_wd = 0; tag = "R10";
    case (op)
      4'h0: begin tag = "R3"; we = 1; wd = ref_alu(fn, a, m_rf[rlo]); end
      4'h8: begin tag = "R4"; we = 1; wd = ref_alu(fn, a, sx); end
      4'h9: begin
        tag = "R6"; we = 1; addr = a + sx;
        if (m_dv[addr[9:2]]) wd = m_dm[addr[9:2]];
        else begin skip_wd = 1; wd = rf_wdata_o; end
      end
      4'h5: begin tag = "R7"; dwe = 1; addr = a + sx; dd = m_rf[rd]; end
      4'h2: begin
        tag = "R8"; y = ref_alu(fn, a, m_rf[rd]);
        if (y[0]) npc = p4 + {sx[29:0], 2'b00};
      end
      4'hB: begin tag = "R9"; we = 1; wd = p4; npc = a + {sx[29:0], 2'b00}; end
      default: ;
    endcase
    if (op == 4'h0 || op == 4'h8) tag = {tag, "/R5"};
    chk(pc_tag, pc_o, m_pc);
    chk(tag, {31'b0, rf_we_o}, {31'b0, we});
    chk(tag, {31'b0, dmem_we_o}, {31'b0, dwe});
    if (we) begin
      chk(tag, {28'b0, rf_waddr_o}, {28'b0, rd});
      if (!skip_wd) chk(tag, rf_wdata_o, wd);
      m_rf[rd] = wd;
    end
    if (dwe) begin
      chk(tag, dmem_addr_o, addr);
      chk(tag, dmem_wdata_o, dd);
      m_dm[addr[9:2]] = dd;
      m_dv[addr[9:2]] = 1'b1;
    end
    m_pc = npc;
    pc_tag = (op == 4'h2 || op == 4'hB) ? tag : "R2";
    @(negedge clk_i);
    #1;
  endtask

  function automatic logic [3:0] rnd_fn();
    logic [3:0] f;
    f = 4'($urandom % 16);
    if ((f == 4'h2 || f == 4'h3 || f > 4'hB) && ($urandom % 4 != 0))
      f = 4'($urandom % 2);
    return f;
  endfunction

  task automatic fill_random();
    int i = 0;
    while (i < 256) begin
      int k = $urandom % 20;
      logic [3:0] rd = 4'($urandom), rs = 4'($urandom), rt = 4'($urandom);
      logic [15:0] imm = 16'($urandom);
      if (k < 6) begin
        prog[i] = enc(4'h0, rnd_fn(), rd, rs, {rt, 12'($urandom)}); i++;
      end else if (k < 11) begin
        prog[i] = enc(4'h8, rnd_fn(), rd, rs, imm); i++;
      end else if (k < 14) begin
        logic [15:0] off = 16'($urandom % 64) - 16'd32;
        prog[i] = enc(4'h5, 4'($urandom), rt, rs, off); i++;
        if (i < 256) begin prog[i] = enc(4'h9, 4'($urandom), rd, rs, off); i++; end
      end else if (k < 17) begin
        prog[i] = enc(4'h2, rnd_fn(), rt, rs, 16'($urandom % 17) - 16'd8); i++;
      end else if (k < 18) begin
        prog[i] = enc(4'hB, 4'($urandom), rd, rs, imm); i++;
      end else begin
        logic [3:0] bad;
        bad = 4'hC + 4'($urandom % 4);
        prog[i] = enc(bad, 4'($urandom), rd, rs, imm); i++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) m_dv[i] = 1'b0;
    // directed program
    for (int i = 0; i < 256; i++) prog[i] = 32'h0;
    prog[0]  = enc(4'h8, 4'h0, 4'd1, 4'd0, 16'd5);
    prog[1]  = enc(4'h8, 4'h0, 4'd2, 4'd0, 16'hFFFD);
    prog[2]  = enc(4'h0, 4'h0, 4'd3, 4'd1, 16'h2000);   // R3 back-to-back use of r1, r2
    prog[3]  = enc(4'h0, 4'h1, 4'd4, 4'd1, 16'h2000);
    prog[4]  = enc(4'h0, 4'h9, 4'd5, 4'd2, 16'h1000);   // -3 < 5 signed
    prog[5]  = enc(4'h5, 4'h0, 4'd3, 4'd1, 16'd3);      // store r3 at 8
    prog[6]  = enc(4'h9, 4'h0, 4'd6, 4'd1, 16'd3);      // load back
    prog[7]  = enc(4'h2, 4'h8, 4'd6, 4'd3, 16'd2);      // equal, taken
    prog[8]  = enc(4'h8, 4'h0, 4'd7, 4'd0, 16'd99);
    prog[9]  = enc(4'h8, 4'h0, 4'd7, 4'd0, 16'd98);
    prog[10] = enc(4'h2, 4'hB, 4'd6, 4'd3, 16'd5);      // not-equal, not taken
    prog[11] = enc(4'hB, 4'h0, 4'd8, 4'd0, 16'd14);     // jump to word 14
    prog[14] = enc(4'hF, 4'h0, 4'd9, 4'd1, 16'h1234);  // unsupported
    prog[15] = enc(4'h8, 4'h5, 4'd10, 4'd0, 16'h8000);
    prog[16] = enc(4'h0, 4'hA, 4'd11, 4'd10, 16'h2000); // -32768 <= -3
    prog[17] = enc(4'h0, 4'h7, 4'd12, 4'd10, 16'hA000);
    prog[18] = enc(4'h0, 4'h3, 4'd13, 4'd1, 16'h1000);  // undefined code
    prog[19] = enc(4'h2, 4'h9, 4'd10, 4'd1, 16'hFFEC);  // 5 < -32768 false
    prog[20] = enc(4'h2, 4'h0, 4'd0, 4'd1, 16'hFFF0);   // add=5, bit0 set -> back to 5
    load_and_start();
    for (int c = 0; c < 60; c++) step();
    // explicit corner values
    chk("R6", m_rf[6], 32'd2);
    chk("R9", m_rf[8], 32'd48);
    // reload word 0 during reset
    prog[0] = enc(4'h8, 4'h0, 4'd1, 4'd0, 16'h0123);
    load_and_start();
    chk("R11", rf_wdata_o, 32'h0000_0123);
    for (int c = 0; c < 40; c++) step();
    // random programs with a reset in the middle of each
    for (int p = 0; p < 6; p++) begin
      fill_random();
      load_and_start();
      for (int c = 0; c < 1500; c++) step();
      @(negedge clk_i);
      rst_ni = 1'b0;
      #1;
      chk("R1", pc_o, 32'h0);
      chk("R1", {31'b0, rf_we_o | dmem_we_o}, 32'h0);
      @(negedge clk_i);
      for (int i = 0; i < 16; i++) m_rf[i] = '0;
      m_pc = '0; pc_tag = "R1";
      rst_ni = 1'b1;
      #1;
      for (int c = 0; c < 300; c++) step();
    end
    finish_run();
  end
endmodule